// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a slave on a two-wire serial bus. An external master uses it to read and write an 8-bit register file that sits next to it. The whole block runs on the system clock. The serial clock and data pins arrive as asynchronous inputs. They pass through a configurable synchronizer before edge detection, and the block finds start and stop conditions from the synchronized levels. The block never drives the data pin high. It only asserts an output-enable, and when that enable is set the pad pulls the line low.

Each transfer covers one register:
- **Write:** the master sends the device address with the direction bit clear, then a register-address byte, then one data byte.
- **Read:** the master sends the device address with the direction bit clear and the register-address byte. It then issues a repeated start and sends the device address again with the direction bit set. The slave answers with the contents of the stored register address, most significant bit first.

A strap input selects one of two fixed device addresses. The strap is captured only while reset is held.

The register file is outside the block. It connects through a write strobe, a register address, write data and combinational read data.

Top module: `twire_regslave`

## Requirements
- R1: A fall of the data line while the serial clock is high is a start condition. A start restarts address reception from any state, in any bit position. A rise of the data line while the serial clock is high is a stop condition. A stop returns the block to idle with the data line released.
- R2: The strap is sampled only while rst_n is low. With the strap at 0 the device address is 7'b1010101. With the strap at 1 it is 7'b0110011. Changing the strap after reset has no effect.
- R3: Bytes are received most significant bit first. After a byte is accepted, the slave holds sda_oe high from the low phase before the ninth clock until the falling edge that ends the ninth clock. The line is therefore low for that clock's whole high phase.
- R4: If bits 7..1 of the first byte after a start differ from the device address, no acknowledge is given. sda_oe stays low for the rest of the transfer, until the next start.
- R5: A write consists of a matching address byte with bit 0 = 0, a register-address byte and a data byte. It gives three acknowledges and exactly one single-cycle rf_we pulse, with rf_addr equal to the register-address byte and rf_wdata equal to the data byte.
- R6: rf_addr holds the last received register-address byte across stops and starts until a new register-address byte arrives. It is 0 after reset.
- R7: A matching address byte with bit 0 = 1 is acknowledged. The slave then sends rf_rdata at rf_addr, most significant bit first. Its output changes only while the serial clock is low.
- R8: After the eighth bit of a read byte, the slave releases the data line for the master's acknowledge clock. It keeps the line released until the next start or stop.
- R9: A start or stop that arrives before all 8 bits of a data byte have been received produces no rf_we pulse.
- R10: sda_oe changes only while the synchronized serial clock is low.
- R11: After the third acknowledge of a write, further bytes get no acknowledge and produce no write until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset; strap captured while low |
| addr_sel | input | 1 | Strap selecting one of two device addresses |
| scl_i | input | 1 | Serial clock pin, asynchronous |
| sda_i | input | 1 | Resolved serial data pin level, asynchronous |
| sda_oe | output | 1 | When high, pad pulls the data line low |
| rf_we | output | 1 | Single-cycle register-file write strobe |
| rf_addr | output | 8 | Register pointer, used for writes and reads |
| rf_wdata | output | 8 | Write data for the register file |
| rf_rdata | input | 8 | Combinational read data at rf_addr |

## Verification
The assertions assume the master obeys the bus rules. Data changes only while the serial clock is low, except for start and stop conditions. Each level is held for many system-clock cycles, so the synchronized clock and data never change in the same cycle. The bench's master keeps every phase of a bit several synchronizer latencies long, and moves the data line only in the middle of a low phase or in a deliberate start or stop. A partial byte is cut off only by a legal start or stop issued while the slave is not driving the line.

// File: rtl/twire_pkg.sv
package twire_pkg;
   localparam int TW_BYTE_W = 8;
   localparam int TW_DEV_W  = 7;
   localparam int TW_CNT_W  = $clog2(TW_BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WDAT,
      ST_TX,
      ST_HOLD
   } tw_state_e;
endpackage

// File: rtl/twire_sync.sv
module twire_sync #(
   parameter int               STAGES  = 2,
   parameter int               W       = 2,
   parameter logic [W-1:0]     RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twire_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("twire_sync: W must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d};
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/twire_cond.sv
module twire_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_lvl   = scl_s;
   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

   // R1: a bus condition needs the clock high for two samples in a row
   p_cond_clock_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |-> ($past(scl_s) && scl_s));
endmodule

// File: rtl/twire_engine.sv
module twire_engine
   import twire_pkg::*;
#(
   parameter logic [TW_BYTE_W-1:0] PTR_INIT = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TW_DEV_W-1:0]  dev_id,
   input  logic                 scl_lvl,
   input  logic                 sda_lvl,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic [TW_BYTE_W-1:0] rf_rdata,
   output logic                 sda_oe,
   output logic                 rf_we,
   output logic [TW_BYTE_W-1:0] rf_addr,
   output logic [TW_BYTE_W-1:0] rf_wdata
);
   localparam logic [TW_CNT_W-1:0] FULL_CNT = TW_CNT_W'(TW_BYTE_W);

   tw_state_e              st_q, nxt_q;
   logic [TW_CNT_W-1:0]    cnt_q;
   logic                   ack_q;
   logic                   oe_q;
   logic                   we_q;
   logic [TW_BYTE_W-1:0]   sh_q;
   logic [TW_BYTE_W-2:0]   tx_q;
   logic [TW_BYTE_W-1:0]   ptr_q;
   logic [TW_BYTE_W-1:0]   wd_q;

   logic byte_full, id_hit, rx_state;

   assign byte_full = (cnt_q == FULL_CNT);
   assign id_hit    = (sh_q[TW_BYTE_W-1:1] == dev_id);
   assign rx_state  = (st_q == ST_DEV) || (st_q == ST_REG) || (st_q == ST_WDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         nxt_q <= ST_IDLE;
         cnt_q <= '0;
         ack_q <= 1'b0;
         oe_q  <= 1'b0;
         we_q  <= 1'b0;
         sh_q  <= '0;
         tx_q  <= '0;
         ptr_q <= PTR_INIT;
         wd_q  <= '0;
      end else begin
         we_q <= 1'b0;
         if (start_det) begin
            st_q  <= ST_DEV;
            cnt_q <= '0;
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
         end else if (stop_det) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
         end else if (rx_state) begin
            if (ack_q) begin
               if (scl_fall) begin
                  ack_q <= 1'b0;
                  cnt_q <= '0;
                  st_q  <= nxt_q;
                  if (nxt_q == ST_TX) begin
                     tx_q <= rf_rdata[TW_BYTE_W-2:0];
                     oe_q <= ~rf_rdata[TW_BYTE_W-1];
                  end else begin
                     oe_q <= 1'b0;
                  end
               end
            end else if (scl_rise && !byte_full) begin
               sh_q  <= {sh_q[TW_BYTE_W-2:0], sda_lvl};
               cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && byte_full) begin
               cnt_q <= '0;
               if (st_q == ST_DEV) begin
                  if (id_hit) begin
                     ack_q <= 1'b1;
                     oe_q  <= 1'b1;
                     nxt_q <= sh_q[0] ? ST_TX : ST_REG;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end else if (st_q == ST_REG) begin
                  ack_q <= 1'b1;
                  oe_q  <= 1'b1;
                  ptr_q <= sh_q;
                  nxt_q <= ST_WDAT;
               end else begin
                  ack_q <= 1'b1;
                  oe_q  <= 1'b1;
                  we_q  <= 1'b1;
                  wd_q  <= sh_q;
                  nxt_q <= ST_HOLD;
               end
            end
         end else if (st_q == ST_TX) begin
            if (scl_rise && !byte_full) begin
               cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
               if (byte_full) begin
                  oe_q  <= 1'b0;
                  cnt_q <= '0;
                  st_q  <= ST_HOLD;
               end else if (cnt_q != '0) begin
                  oe_q <= ~tx_q[TW_BYTE_W-2];
                  tx_q <= {tx_q[TW_BYTE_W-3:0], 1'b0};
               end
            end
         end
      end
   end

   assign sda_oe   = oe_q;
   assign rf_we    = we_q;
   assign rf_addr  = ptr_q;
   assign rf_wdata = wd_q;

   // R1: a start always reopens address reception with the line released
   p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st_q == ST_DEV && cnt_q == '0 && !oe_q));
   // R1: a lone stop parks the engine
   p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (st_q == ST_IDLE && !oe_q));
   // R3: during an acknowledge high phase the line is pulled low
   p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q && scl_lvl) |-> oe_q);
   // R4 / R8 / R11: idle and hold states never drive the line
   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE || st_q == ST_HOLD) |-> !oe_q);
   // R5: the write strobe is a single cycle
   p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);
   // R9: a write only follows a completed byte, in the clock low phase
   p_we_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !scl_lvl);
   // R10: driven value only moves while the clock is low
   p_oe_move_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_lvl);
endmodule

// File: rtl/twire_regslave.sv
module twire_regslave
   import twire_pkg::*;
#(
   parameter int                   SYNC_STAGES = 2,
   parameter logic [TW_DEV_W-1:0]  DEV_ID_LO   = 7'b1010101,
   parameter logic [TW_DEV_W-1:0]  DEV_ID_HI   = 7'b0110011,
   parameter logic [TW_BYTE_W-1:0] PTR_INIT    = 8'h00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_sel,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   output logic                 rf_we,
   output logic [TW_BYTE_W-1:0] rf_addr,
   output logic [TW_BYTE_W-1:0] rf_wdata,
   input  logic [TW_BYTE_W-1:0] rf_rdata
);
   generate
      if (DEV_ID_LO == DEV_ID_HI) begin : g_bad_ids
         $error("twire_regslave: the two device addresses must differ");
      end
   endgenerate

   logic                strap_q;
   logic [TW_DEV_W-1:0] dev_id;
   logic [1:0]          pins_s;
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_q <= addr_sel;
      end
   end

   assign dev_id = strap_q ? DEV_ID_HI : DEV_ID_LO;

   twire_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (2),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (pins_s)
   );

   twire_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (pins_s[1]),
      .sda_s     (pins_s[0]),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   twire_engine #(
      .PTR_INIT (PTR_INIT)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_id    (dev_id),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rf_rdata  (rf_rdata),
      .sda_oe    (sda_oe),
      .rf_we     (rf_we),
      .rf_addr   (rf_addr),
      .rf_wdata  (rf_wdata)
   );

   // R2: the strap copy never moves outside reset
   p_strap_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(strap_q));
endmodule

// File: tb/twire_regslave_bench.sv
module twire_regslave_bench;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_sel = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic       sda_oe, rf_we;
   logic [7:0] rf_addr, rf_wdata, rf_rdata;
   logic [7:0] mem [256] = '{default: 8'h00};
   int         we_cnt = 0;
   int         total = 0;
   int         bad = 0;

   always #5 clk = ~clk;

   assign sda_bus  = sda_m & ~sda_oe;
   assign rf_rdata = mem[rf_addr];

   always @(posedge clk) begin
      if (rf_we) begin
         mem[rf_addr] <= rf_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   twire_regslave u_twire_regslave (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_sel (addr_sel),
      .scl_i    (scl_m),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .rf_we    (rf_we),
      .rf_addr  (rf_addr),
      .rf_wdata (rf_wdata),
      .rf_rdata (rf_rdata)
   );

   // {register address, data}: write, then read back
   localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h015A, 16'h7F00,
                                       16'h80FF, 16'hFE3C, 16'h0177};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input logic b, output logic s0, output logic s1);
      wait_n(Q); sda_m = b;
      wait_n(Q); scl_m = 1'b1;
      wait_n(Q); s0 = sda_bus;
      wait_n(Q - 1); s1 = sda_bus;
      wait_n(1); scl_m = 1'b0;
   endtask

   task automatic bus_start();
      wait_n(Q); sda_m = 1'b1;
      wait_n(Q); scl_m = 1'b1;
      wait_n(Q); sda_m = 1'b0;
      wait_n(Q); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wait_n(Q); sda_m = 1'b0;
      wait_n(Q); scl_m = 1'b1;
      wait_n(Q); sda_m = 1'b1;
      wait_n(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      logic s0, s1;
      for (int i = 7; i > 7 - n; i--) put_bit(b[i], s0, s1);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s0, s1;
      send_bits(b, 8);
      put_bit(1'b1, s0, s1);
      acked = !s0 && !s1;
   endtask

   task automatic recv_byte(output logic [7:0] d, output logic steady, output logic released);
      logic s0, s1;
      steady = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         put_bit(1'b1, s0, s1);
         d[i] = s0;
         if (s0 !== s1) steady = 1'b0;
      end
      put_bit(1'b1, s0, s1);
      released = s0 && s1;
   endtask

   task automatic do_write(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] wd,
                           output logic [2:0] acks);
      bus_start();
      send_byte({dev[6:0], 1'b0}, acks[2]);
      send_byte(ra, acks[1]);
      send_byte(wd, acks[0]);
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] dev, input logic [7:0] ra, output logic [7:0] rd,
                          output logic [2:0] acks, output logic steady, output logic released);
      bus_start();
      send_byte({dev[6:0], 1'b0}, acks[2]);
      send_byte(ra, acks[1]);
      bus_start();
      send_byte({dev[6:0], 1'b1}, acks[0]);
      recv_byte(rd, steady, released);
      bus_stop();
   endtask

   task automatic do_reset(input logic sel);
      rst_n = 1'b0;
      addr_sel = sel;
      wait_n(6);
      rst_n = 1'b1;
      wait_n(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [2:0] acks;
      logic [7:0] rd;
      logic       steady, released, ok;
      int         w0;

      do_reset(1'b0);
      chk("R10 reset sda_oe", sda_oe, 0);
      chk("R5 reset rf_we", rf_we, 0);
      chk("R6 reset rf_addr", rf_addr, 8'h00);

      // R5 R7 R3 R8: vector table, device address 7'b1010101
      for (int v = 0; v < 6; v++) begin
         do_write(8'h55, VEC[v][15:8], VEC[v][7:0], acks);
         chk("R3/R5 write acks", acks, 3'b111);
         chk("R5 stored data", mem[VEC[v][15:8]], VEC[v][7:0]);
         chk("R6 pointer after write", rf_addr, VEC[v][15:8]);
         do_read(8'h55, VEC[v][15:8], rd, acks, steady, released);
         chk("R7 read acks", acks, 3'b111);
         chk("R7 read data", rd, VEC[v][7:0]);
         chk("R7 bits steady while clock high", steady, 1);
         chk("R8 released for master ack", released, 1);
         chk("R1 released after stop", sda_oe, 0);
      end

      // R6: read with no address phase uses stored pointer (0x01 holds 0x77)
      bus_start();
      send_byte(8'hAB, ok);
      recv_byte(rd, steady, released);
      bus_stop();
      chk("R6 pointer read ack", ok, 1);
      chk("R6 pointer read data", rd, 8'h77);

      // R4: other device address gets no acknowledge, later bytes ignored
      w0 = we_cnt;
      bus_start();
      send_byte(8'h66, ok);
      chk("R4 no ack on mismatch", ok, 0);
      send_byte(8'h30, ok);
      chk("R4 later byte not acked", ok, 0);
      send_byte(8'h12, ok);
      chk("R4 sda_oe released", sda_oe, 0);
      bus_stop();
      chk("R4 no write on mismatch", we_cnt, w0);
      chk("R4 pointer kept", rf_addr, 8'h01);

      // R9: stop in middle of data byte
      w0 = we_cnt;
      bus_start();
      send_byte(8'hAA, ok);
      send_byte(8'h10, ok);
      send_bits(8'h99, 4);
      bus_stop();
      chk("R9 no write on stop abort", we_cnt, w0);
      chk("R9 target untouched", mem[8'h10], 8'h00);

      // R9 R1: repeated start in middle of data byte, then full write
      bus_start();
      send_byte(8'hAA, ok);
      send_byte(8'h11, ok);
      send_bits(8'hE7, 5);
      do_write(8'h55, 8'h12, 8'hC3, acks);
      chk("R9 one write after start abort", we_cnt, w0 + 1);
      chk("R9 aborted target untouched", mem[8'h11], 8'h00);
      chk("R1 write after restart", mem[8'h12], 8'hC3);

      // R1: start in middle of address byte
      bus_start();
      send_bits(8'hAA, 3);
      do_write(8'h55, 8'h13, 8'h5E, acks);
      chk("R1 acks after mid-address start", acks, 3'b111);
      chk("R1 data after mid-address start", mem[8'h13], 8'h5E);

      // R11: extra byte after a complete write
      w0 = we_cnt;
      bus_start();
      send_byte(8'hAA, ok);
      send_byte(8'h20, ok);
      send_byte(8'h44, ok);
      send_byte(8'h99, ok);
      chk("R11 extra byte not acked", ok, 0);
      bus_stop();
      chk("R11 single write", we_cnt, w0 + 1);
      chk("R11 data kept", mem[8'h20], 8'h44);

      // R2: strap high at reset, changed afterwards
      do_reset(1'b1);
      chk("R6 pointer reset", rf_addr, 8'h00);
      addr_sel = 1'b0;
      do_write(8'h33, 8'h40, 8'h81, acks);
      chk("R2 strap-high address acks", acks, 3'b111);
      chk("R2 strap-high write", mem[8'h40], 8'h81);
      bus_start();
      send_byte(8'hAA, ok);
      bus_stop();
      chk("R2 low address refused after strap change", ok, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule